// File: doc/BRIEF.md
# Reset Exception Entry Sequencer

This block decides which reset is in force and what the processor sees once that reset ends. It watches three reset requests: an asynchronous power-on request, a synchronous manual request, and a debug reset. The debug reset is turned on and off by 4-bit command codes written through a debug port. While any request is active, the block holds the core and peripherals in reset. It also drives a mask of initialization strobes whose width depends on the highest-priority request that is active.

When every request has gone away, the block closes the reset episode. In the next cycle it writes the exception code of the strongest request seen during the episode into the exception-event register, loads the fixed reset vector into the program-counter output, and raises a one-cycle load pulse. The pipeline, the peripheral registers and the debug shifter that delivers the command codes are outside this block.

Top module: `rst_entry_seq`

## Requirements
- R1: After a cycle with `rst` high and no request active, `hold_o`=0, `init_o`=0, `pc_load_o`=0, `expevt_o`=0x000, `pc_vec_o`=0, and the debug reset is off.
- R2: Raising `por_req_i` sets `hold_o`=1 and `init_o`=5'b11111 at once, without waiting for a clock edge. After `por_req_i` falls, these stay in force until the second rising edge.
- R3: While `man_req_i` is high, `hold_o`=1 and `init_o`=5'b01111 (bit 4, the power-on-only group, stays clear).
- R4: A write with `dbg_cmd_we_i`=1 and `dbg_cmd_i`=4'b0111 turns the debug reset on from the next edge. A write of 4'b0110 turns it off. While it is on, `hold_o`=1 and `init_o`=5'b01111.
- R5: A command code other than 4'b0111 or 4'b0110, or any code presented with `dbg_cmd_we_i`=0, leaves the debug reset state unchanged.
- R6: When several requests are active, `init_o` follows the highest-priority one. The order is power-on, then manual, then debug.
- R7: When a clock edge sees no request active after at least one active cycle, `pc_load_o` is 1 for exactly the following cycle and `pc_vec_o` equals 0xA0000000.
- R8: At that same edge, `expevt_o` takes the code of the highest-priority request seen during the episode: power-on 0x000, manual 0x020, debug 0x000. At all other times it keeps its value.
- R9: `pc_load_o` is raised once per episode and never in a cycle that follows an active-request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer |
| por_req_i | input | 1 | Power-on reset request, asynchronous |
| man_req_i | input | 1 | Manual reset request, synchronous |
| dbg_cmd_i | input | 4 | Debug command code |
| dbg_cmd_we_i | input | 1 | Debug command write strobe |
| hold_o | output | 1 | Core and peripherals held in reset |
| init_o | output | 5 | Init strobes: 0 status, 1 vector base, 2 CPU, 3 peripherals, 4 power-on-only |
| expevt_o | output | 12 | Exception-event code register |
| pc_load_o | output | 1 | One-cycle program-counter load pulse |
| pc_vec_o | output | 32 | Loaded reset vector |

## Verification
The bench builds the block with a two-stage power-on synchronizer, a 32-bit vector and the reset vector 0xA0000000. With these values the two-edge release delay of the power-on request can be seen, and the exact vector can be compared on each load. Because a manual episode leaves 0x020 in the register, a following power-on or debug episode must visibly rewrite it to 0x000. Overlapping episodes in which the strongest request leaves first show that the code comes from the strongest request of the episode, not from the last one to leave.

// File: rtl/rst_entry_pkg.sv
package rst_entry_pkg;

    localparam int CODE_W = 12;
    localparam int INIT_W = 5;
    localparam int CMD_W  = 4;

    // init strobe bit positions
    localparam int INIT_SR       = 0;
    localparam int INIT_VBR      = 1;
    localparam int INIT_CPU      = 2;
    localparam int INIT_PERIPH   = 3;
    localparam int INIT_POR_ONLY = 4;

    localparam logic [CMD_W-1:0]  CMD_ARM    = 4'b0111;
    localparam logic [CMD_W-1:0]  CMD_DISARM = 4'b0110;

    localparam logic [CODE_W-1:0] CODE_POR = 12'h000;
    localparam logic [CODE_W-1:0] CODE_MAN = 12'h020;
    localparam logic [CODE_W-1:0] CODE_DBG = 12'h000;

    // ordered by priority: larger value wins
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_DBG  = 2'd1,
        SRC_MAN  = 2'd2,
        SRC_POR  = 2'd3
    } rst_src_e;

    typedef struct packed {
        logic por;
        logic man;
        logic dbg;
    } src_vec_t;

    function automatic rst_src_e pick_src(src_vec_t v);
        if (v.por)      return SRC_POR;
        else if (v.man) return SRC_MAN;
        else if (v.dbg) return SRC_DBG;
        else            return SRC_NONE;
    endfunction

    function automatic logic [INIT_W-1:0] mask_of(rst_src_e s);
        logic [INIT_W-1:0] m;
        m = '0;
        if (s != SRC_NONE) begin
            m[INIT_SR]     = 1'b1;
            m[INIT_VBR]    = 1'b1;
            m[INIT_CPU]    = 1'b1;
            m[INIT_PERIPH] = 1'b1;
        end
        if (s == SRC_POR) m[INIT_POR_ONLY] = 1'b1;
        return m;
    endfunction

    function automatic logic [CODE_W-1:0] code_of(rst_src_e s);
        case (s)
            SRC_MAN: return CODE_MAN;
            SRC_DBG: return CODE_DBG;
            default: return CODE_POR;
        endcase
    endfunction

endpackage

// File: rtl/rst_por_sync.sv
module rst_por_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_async,
    output logic req_sync
);
    logic [STAGES-1:0] stage_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or posedge req_async) begin
                if (req_async)  stage_q <= '1;
                else if (rst)   stage_q <= '0;
                else            stage_q <= '0;
            end
        end else begin : g_chain
            always_ff @(posedge clk or posedge req_async) begin
                if (req_async)  stage_q <= '1;
                else if (rst)   stage_q <= '0;
                else            stage_q <= {stage_q[STAGES-2:0], 1'b0};
            end
        end
    endgenerate

    assign req_sync = stage_q[STAGES-1];
endmodule

// File: rtl/rst_dbg_cmd.sv
module rst_dbg_cmd
    import rst_entry_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CMD_W-1:0] cmd,
    input  logic             cmd_we,
    output logic             armed
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (cmd_we) begin
            case (cmd)
                CMD_ARM:    armed_q <= 1'b1;
                CMD_DISARM: armed_q <= 1'b0;
                default:    armed_q <= armed_q;
            endcase
        end
    end

    assign armed = armed_q;
endmodule

// File: rtl/rst_episode.sv
module rst_episode
    import rst_entry_pkg::*;
#(
    parameter int               VEC_W     = 32,
    parameter logic [VEC_W-1:0] RESET_VEC = 32'hA000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  src_vec_t          src,
    output logic [CODE_W-1:0] expevt,
    output logic              pc_load,
    output logic [VEC_W-1:0]  pc_vec
);
    rst_src_e          cur_src;
    rst_src_e          win_q;
    logic              open_q;
    logic              any_src;
    logic [CODE_W-1:0] expevt_q;
    logic              load_q;
    logic [VEC_W-1:0]  vec_q;

    assign cur_src = pick_src(src);
    assign any_src = (cur_src != SRC_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q    <= SRC_NONE;
            open_q   <= 1'b0;
            expevt_q <= '0;
            load_q   <= 1'b0;
            vec_q    <= '0;
        end else if (any_src) begin
            open_q <= 1'b1;
            load_q <= 1'b0;
            if (cur_src > win_q) win_q <= cur_src;
        end else if (open_q) begin
            expevt_q <= code_of(win_q);
            vec_q    <= RESET_VEC;
            load_q   <= 1'b1;
            open_q   <= 1'b0;
            win_q    <= SRC_NONE;
        end else begin
            load_q <= 1'b0;
        end
    end

    assign expevt  = expevt_q;
    assign pc_load = load_q;
    assign pc_vec  = vec_q;
endmodule

// File: rtl/rst_entry_seq.sv
module rst_entry_seq
    import rst_entry_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter int               VEC_W       = 32,
    parameter logic [VEC_W-1:0] RESET_VEC   = 32'hA000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por_req_i,
    input  logic              man_req_i,
    input  logic [CMD_W-1:0]  dbg_cmd_i,
    input  logic              dbg_cmd_we_i,
    output logic              hold_o,
    output logic [INIT_W-1:0] init_o,
    output logic [CODE_W-1:0] expevt_o,
    output logic              pc_load_o,
    output logic [VEC_W-1:0]  pc_vec_o
);
    logic     por_s;
    logic     dbg_armed;
    src_vec_t src;

    rst_por_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
        .clk       (clk),
        .rst       (rst),
        .req_async (por_req_i),
        .req_sync  (por_s)
    );

    rst_dbg_cmd u_dbg (
        .clk    (clk),
        .rst    (rst),
        .cmd    (dbg_cmd_i),
        .cmd_we (dbg_cmd_we_i),
        .armed  (dbg_armed)
    );

    assign src.por = por_s;
    assign src.man = man_req_i;
    assign src.dbg = dbg_armed;

    assign init_o = mask_of(pick_src(src));
    assign hold_o = src.por | src.man | src.dbg;

    rst_episode #(.VEC_W(VEC_W), .RESET_VEC(RESET_VEC)) u_episode (
        .clk     (clk),
        .rst     (rst),
        .src     (src),
        .expevt  (expevt_o),
        .pc_load (pc_load_o),
        .pc_vec  (pc_vec_o)
    );
endmodule

// File: rtl/rst_entry_seq_chk.sv
module rst_entry_seq_chk
    import rst_entry_pkg::*;
#(
    parameter int               VEC_W     = 32,
    parameter logic [VEC_W-1:0] RESET_VEC = 32'hA000_0000
) (
    input logic              clk,
    input logic              rst,
    input logic              por_req_i,
    input logic [CMD_W-1:0]  dbg_cmd_i,
    input logic              dbg_cmd_we_i,
    input logic              hold_o,
    input logic [INIT_W-1:0] init_o,
    input logic [CODE_W-1:0] expevt_o,
    input logic              pc_load_o,
    input logic [VEC_W-1:0]  pc_vec_o
);
    assert_por_full_mask_R2: assert property (@(posedge clk) disable iff (rst)
        por_req_i |-> (init_o == 5'b11111));

    assert_dbg_arm_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (dbg_cmd_we_i && dbg_cmd_i == CMD_ARM) |=> hold_o);

    assert_load_vector_R7: assert property (@(posedge clk) disable iff (rst)
        pc_load_o |-> (pc_vec_o == RESET_VEC));

    assert_load_single_R7: assert property (@(posedge clk) disable iff (rst)
        pc_load_o |=> !pc_load_o);

    assert_code_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (!pc_load_o && !$past(rst)) |-> $stable(expevt_o));

    assert_load_after_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (pc_load_o && !$past(rst)) |-> !$past(hold_o));
endmodule

bind rst_entry_seq rst_entry_seq_chk #(.VEC_W(VEC_W), .RESET_VEC(RESET_VEC)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .por_req_i    (por_req_i),
    .dbg_cmd_i    (dbg_cmd_i),
    .dbg_cmd_we_i (dbg_cmd_we_i),
    .hold_o       (hold_o),
    .init_o       (init_o),
    .expevt_o     (expevt_o),
    .pc_load_o    (pc_load_o),
    .pc_vec_o     (pc_vec_o)
);

// File: tb/rst_entry_seq_tb_top.sv
module rst_entry_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        por_req = 1'b0;
    logic        man_req = 1'b0;
    logic [3:0]  cmd = 4'h0;
    logic        cmd_we = 1'b0;
    logic        hold;
    logic [4:0]  init;
    logic [11:0] expevt;
    logic        pc_load;
    logic [31:0] pc_vec;

    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string tag = "R1";

    // reference model state
    int m_ps = 0;       // synchronizer stages as 2-bit number
    int m_dbg = 0;
    int m_open = 0;
    int m_win = 0;      // 0 none,1 dbg,2 man,3 por
    int m_code = 0;
    int m_load = 0;
    int m_vec = 0;

    always #4 clk = ~clk;   // 125 MHz

    rst_entry_seq #(.SYNC_STAGES(2), .VEC_W(32), .RESET_VEC(32'hA000_0000)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .por_req_i    (por_req),
        .man_req_i    (man_req),
        .dbg_cmd_i    (cmd),
        .dbg_cmd_we_i (cmd_we),
        .hold_o       (hold),
        .init_o       (init),
        .expevt_o     (expevt),
        .pc_load_o    (pc_load),
        .pc_vec_o     (pc_vec)
    );

    function automatic int top_src();
        int p;
        p = (por_req || (m_ps >= 2)) ? 1 : 0;
        if (p != 0) return 3;
        if (man_req) return 2;
        if (m_dbg != 0) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        int s;
        s = top_src();
        if (rst) begin
            m_open = 0; m_win = 0; m_code = 0; m_load = 0; m_vec = 0;
        end else if (s != 0) begin
            m_open = 1; m_load = 0;
            if (s > m_win) m_win = s;
        end else if (m_open != 0) begin
            m_code = (m_win == 2) ? 32'h020 : 0;
            m_vec  = 32'hA000_0000;
            m_load = 1; m_open = 0; m_win = 0;
        end else begin
            m_load = 0;
        end
        if (rst) m_dbg = 0;
        else if (cmd_we && cmd == 4'b0111) m_dbg = 1;
        else if (cmd_we && cmd == 4'b0110) m_dbg = 0;
        if (por_req) m_ps = 3;
        else if (rst) m_ps = 0;
        else m_ps = (m_ps << 1) & 3;
    end

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // compare against the model mid-cycle, away from the active edge
    always @(negedge clk) begin
        int s, em;
        if (!done) begin
            s  = top_src();
            em = (s == 3) ? 5'b11111 : (s != 0) ? 5'b01111 : 0;
            chk("hold_o", int'(hold), (s != 0) ? 1 : 0);
            chk("init_o", int'(init), em);
            chk("expevt_o", int'(expevt), m_code);
            chk("pc_load_o", int'(pc_load), m_load);
            chk("pc_vec_o", int'(pc_vec), m_vec);
        end
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(logic [3:0] c, logic we);
        cmd = c; cmd_we = we;
        cyc(1);
        cmd_we = 1'b0; cmd = 4'h0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        tag = "R1";
        cyc(3);
        rst = 1'b0;
        cyc(2);
        // R2: power-on request, async assert, two-edge release
        tag = "R2";
        #1 por_req = 1'b1;
        cyc(3);
        por_req = 1'b0;
        cyc(5);
        // R3: manual request, code 0x020
        tag = "R3";
        man_req = 1'b1;
        cyc(3);
        man_req = 1'b0;
        cyc(3);
        // R4: debug arm / disarm rewrites code to 0x000
        tag = "R4";
        wr(4'b0111, 1'b1);
        cyc(3);
        wr(4'b0110, 1'b1);
        cyc(3);
        // R5: ignored codes and strobes
        tag = "R5";
        wr(4'b0111, 1'b0);
        wr(4'b0101, 1'b1);
        wr(4'b1111, 1'b1);
        cyc(2);
        wr(4'b0111, 1'b1);
        wr(4'b0000, 1'b1);
        wr(4'b0110, 1'b0);
        wr(4'b1110, 1'b1);
        cyc(2);
        wr(4'b0110, 1'b1);
        cyc(3);
        // R6: priority ordering while stacked
        tag = "R6";
        wr(4'b0111, 1'b1);
        man_req = 1'b1;
        cyc(2);
        por_req = 1'b1;
        cyc(2);
        por_req = 1'b0;
        cyc(3);
        man_req = 1'b0;
        cyc(2);
        wr(4'b0110, 1'b1);
        cyc(3);
        // R8: strongest request of the episode supplies the code
        tag = "R8";
        man_req = 1'b1;
        wr(4'b0111, 1'b1);
        cyc(1);
        man_req = 1'b0;
        cyc(2);
        wr(4'b0110, 1'b1);
        cyc(3);
        // R7 / R9: back-to-back episodes each load once
        tag = "R7";
        man_req = 1'b1;
        cyc(1);
        man_req = 1'b0;
        cyc(1);
        tag = "R9";
        man_req = 1'b1;
        cyc(1);
        man_req = 1'b0;
        cyc(4);
        // R1: reset mid-operation clears everything
        tag = "R1";
        man_req = 1'b1;
        cyc(2);
        man_req = 1'b0;
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
        cyc(3);
        finish_run();
    end
endmodule